// File: doc/BRIEF.md
# Two-wire configuration register slave

This block is a slave on a two-wire serial bus. It holds the configuration state of a receiver front end. It stores twelve writable byte registers and shows two read-only status bytes. It drives every stored byte onto a flat parallel bus, and it also decodes the fields that the rest of the chip uses directly: the frequency divide word, the reference divider, the filter code, the oscillator start code, the autoselect enable and the output divide select.

A bus master writes one register or a run of consecutive registers in a single transaction. To read, the master first sets the register pointer with a write, then issues a repeated start with the read bit set. The pointer steps after every byte, in both directions. SCL and SDA are sampled in the system clock domain, and SDA is driven only low, through an output-enable.

Two side effects come from bus traffic. Every data byte written to the low byte of the divide word produces a one-cycle pulse that starts the oscillator band search. A power-up flag in the first status byte stays set until that byte has been read in a transaction that the master closes with a stop condition.

Top module: `cfgbus_slave`

## Requirements
- R1: The 7-bit device address is 1100000 when `addr_sel` is 0 and 1100001 when it is 1 (bus bytes 0xC0/0xC1 and 0xC2/0xC3). Any other address byte gets no acknowledge, and the transaction that follows has no effect.
- R2: A write transaction is start, device address with R/W=0, register pointer byte, then one or more data bytes. Each data byte is stored at the pointer, and the pointer then advances by one.
- R3: A read transaction sets the pointer with a write, then issues a repeated start with R/W=1. Bytes come back MSB first, and the pointer advances after each byte. After a master NACK the slave releases SDA and sends nothing more until the next start.
- R4: The slave acknowledges by holding SDA low through the ninth SCL pulse. It begins driving SDA low only while SCL is low.
- R5: The 15-bit divide word `n_word` is {reg 0x00 bits 6:0, reg 0x01 bits 7:0}. Its reset value is 950.
- R6: Status byte 0x0C is {power-up flag, `st_flags`[2:0], 0000}. Status byte 0x0D is {`st_band`[4:0], `st_adc`[2:0]}. The power-up flag is 1 after reset. It clears at the stop condition of a transaction in which byte 0x0C was sent to the master, and no other traffic clears it.
- R7: `search_start` pulses high for exactly one cycle for each data byte written to register 0x01. A write to any other register does not raise it.
- R8: Reset values are 0x00=0x03, 0x01=0xB6, 0x05=0x04, 0x06=0xC0, 0x07=0xCC, 0x08=0x4B, and 0x00 for every other writable register. The decoded fields are `r_div`=0x05[4:0], `div8_sel`=0x06[7], `vco_start`=0x07[7:3], `auto_en`=0x07[2] and `lpf_code`=0x08. Register k appears on `cfg_flat`[8k+7:8k].
- R9: Data bytes sent to 0x0C, 0x0D or any higher address are acknowledged and discarded. Writable registers read back their stored value. Addresses above 0x0D read as 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 10x the bus bit rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as received |
| sda_i | input | 1 | Bus data line as received |
| sda_oe | output | 1 | When 1, the pad pulls SDA low |
| addr_sel | input | 1 | Selects the device address LSB |
| st_flags | input | 3 | Search/lock flags shown in status byte 0x0C |
| st_band | input | 5 | Selected band shown in status byte 0x0D |
| st_adc | input | 3 | Tuning-voltage code shown in status byte 0x0D |
| cfg_flat | output | 96 | All writable registers, register k at bits 8k+7:8k |
| n_word | output | 15 | Divide word |
| r_div | output | 5 | Reference divider |
| lpf_code | output | 8 | Baseband filter code |
| vco_start | output | 5 | Oscillator start code |
| auto_en | output | 1 | Autoselect enable |
| div8_sel | output | 1 | Output divide-by-8 select |
| search_start | output | 1 | One-cycle band search start pulse |

## Verification
The power-up flag is the hardest behaviour to reach from the ports. It clears only when a read of byte 0x0C and a closing stop come together, so the stimulus orders three transactions:
- a read of byte 0x0D alone, which must leave the flag set;
- a two-byte read that starts at 0x0C, which must still return the flag as 1;
- a later read, which must return it as 0.

A write aimed at 0x0C is also sent before that point, and the flag must survive it. The strobe behaviour is reached by writes that start at 0x00: one covers only 0x00, the next runs on into 0x01, and a direct write to 0x01 follows, so each case yields a known pulse count.

// File: rtl/cfgbus_pkg.sv
package cfgbus_pkg;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_RX,
      PH_ACK,
      PH_TX,
      PH_MACK
   } phase_t;

   typedef enum logic [1:0] {
      BY_DEV,
      BY_PTR,
      BY_DATA
   } bytekind_t;

   function automatic logic [7:0] reg_reset_val(input int idx);
      case (idx)
         0:       return 8'h03;
         1:       return 8'hB6;
         5:       return 8'h04;
         6:       return 8'hC0;
         7:       return 8'hCC;
         8:       return 8'h4B;
         default: return 8'h00;
      endcase
   endfunction

endpackage

// File: rtl/cfgbus_pinsync.sv
module cfgbus_pinsync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);

   initial begin
      assert (STAGES >= 2) else $error("cfgbus_pinsync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] scl_ff, sda_ff;
   logic              scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_ff <= '1;
         sda_ff <= '1;
         scl_q  <= 1'b1;
         sda_q  <= 1'b1;
      end else begin
         scl_ff <= {scl_ff[STAGES-2:0], scl_i};
         sda_ff <= {sda_ff[STAGES-2:0], sda_i};
         scl_q  <= scl_ff[STAGES-1];
         sda_q  <= sda_ff[STAGES-1];
      end
   end

   assign scl_s     = scl_ff[STAGES-1];
   assign sda_s     = sda_ff[STAGES-1];
   assign scl_rise  = scl_s & ~scl_q;
   assign scl_fall  = ~scl_s & scl_q;
   assign start_det = scl_s & scl_q & sda_q & ~sda_s;
   assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/cfgbus_proto.sv
module cfgbus_proto
   import cfgbus_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR = 7'b1100000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_s,
   input  logic       sda_s,
   input  logic       scl_rise,
   input  logic       scl_fall,
   input  logic       start_det,
   input  logic       stop_det,
   input  logic       addr_sel,
   input  logic [7:0] rd_data,
   output logic       sda_oe,
   output logic       wr_en,
   output logic [7:0] wr_addr,
   output logic [7:0] wr_data,
   output logic [7:0] rd_addr,
   output logic       rd_take
);

   initial begin
      assert (DEV_ADDR[0] == 1'b0) else $error("cfgbus_proto: DEV_ADDR LSB must be 0");
   end

   phase_t     phase;
   bytekind_t  kind;
   logic [3:0] cnt;
   logic [7:0] sh;
   logic [7:0] ptr;
   logic       is_read;
   logic       mack_ok;
   logic       byte_full;
   logic [6:0] my_addr;

   assign my_addr = {DEV_ADDR[6:1], addr_sel};
   assign rd_addr = ptr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase     <= PH_IDLE;
         kind      <= BY_DEV;
         cnt       <= '0;
         sh        <= '0;
         ptr       <= '0;
         is_read   <= 1'b0;
         mack_ok   <= 1'b0;
         byte_full <= 1'b0;
         sda_oe    <= 1'b0;
         wr_en     <= 1'b0;
         wr_addr   <= '0;
         wr_data   <= '0;
         rd_take   <= 1'b0;
      end else begin
         wr_en   <= 1'b0;
         rd_take <= 1'b0;
         if (start_det) begin
            phase     <= PH_RX;
            kind      <= BY_DEV;
            cnt       <= '0;
            byte_full <= 1'b0;
            sda_oe    <= 1'b0;
         end else if (stop_det) begin
            phase  <= PH_IDLE;
            sda_oe <= 1'b0;
         end else begin
            case (phase)
               PH_RX: begin
                  if (scl_rise && !byte_full) begin
                     sh  <= {sh[6:0], sda_s};
                     cnt <= cnt + 4'd1;
                     if (cnt == 4'd7) byte_full <= 1'b1;
                  end else if (scl_fall && byte_full) begin
                     byte_full <= 1'b0;
                     cnt       <= '0;
                     case (kind)
                        BY_DEV: begin
                           if (sh[7:1] == my_addr) begin
                              is_read <= sh[0];
                              phase   <= PH_ACK;
                              sda_oe  <= 1'b1;
                           end else begin
                              phase <= PH_IDLE;
                           end
                        end
                        BY_PTR: begin
                           ptr    <= sh;
                           phase  <= PH_ACK;
                           sda_oe <= 1'b1;
                        end
                        default: begin
                           wr_en   <= 1'b1;
                           wr_addr <= ptr;
                           wr_data <= sh;
                           ptr     <= ptr + 8'd1;
                           phase   <= PH_ACK;
                           sda_oe  <= 1'b1;
                        end
                     endcase
                  end
               end
               PH_ACK: begin
                  if (scl_fall) begin
                     if (kind == BY_DEV && is_read) begin
                        phase   <= PH_TX;
                        sh      <= rd_data;
                        sda_oe  <= ~rd_data[7];
                        rd_take <= 1'b1;
                        cnt     <= '0;
                     end else begin
                        phase  <= PH_RX;
                        sda_oe <= 1'b0;
                        kind   <= (kind == BY_DEV) ? BY_PTR : BY_DATA;
                     end
                  end
               end
               PH_TX: begin
                  if (scl_fall) begin
                     if (cnt == 4'd7) begin
                        phase  <= PH_MACK;
                        sda_oe <= 1'b0;
                        ptr    <= ptr + 8'd1;
                     end else begin
                        sh     <= {sh[6:0], 1'b0};
                        sda_oe <= ~sh[6];
                        cnt    <= cnt + 4'd1;
                     end
                  end
               end
               PH_MACK: begin
                  if (scl_rise) begin
                     mack_ok <= ~sda_s;
                  end else if (scl_fall) begin
                     if (mack_ok) begin
                        phase   <= PH_TX;
                        sh      <= rd_data;
                        sda_oe  <= ~rd_data[7];
                        rd_take <= 1'b1;
                        cnt     <= '0;
                     end else begin
                        phase <= PH_IDLE;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   // R4: the slave begins pulling SDA low only while SCL is low
   assert_drive_scl_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe) |-> !scl_s);

   // R2: every stored data byte is followed by a pointer one above it
   assert_ptr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (ptr == wr_addr + 8'd1));

   // R3: an idle slave never holds the data line
   assert_idle_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_IDLE) |-> !sda_oe);

endmodule

// File: rtl/cfgbus_regfile.sv
module cfgbus_regfile
   import cfgbus_pkg::*;
#(
   parameter int NUM_WREG  = 12,
   parameter int STRB_ADDR = 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [7:0]            wr_addr,
   input  logic [7:0]            wr_data,
   input  logic [7:0]            rd_addr,
   input  logic                  rd_take,
   input  logic                  bus_stop,
   input  logic [2:0]            st_flags,
   input  logic [4:0]            st_band,
   input  logic [2:0]            st_adc,
   output logic [7:0]            rd_data,
   output logic [NUM_WREG*8-1:0] cfg_flat,
   output logic                  search_start,
   output logic                  por_flag
);

   localparam int STAT0 = NUM_WREG;
   localparam int STAT1 = NUM_WREG + 1;

   initial begin
      assert (STAT1 < 256) else $error("cfgbus_regfile: register space exceeds pointer range");
      assert (STRB_ADDR < NUM_WREG) else $error("cfgbus_regfile: STRB_ADDR must be writable");
   end

   for (genvar g = 0; g < NUM_WREG; g++) begin : g_reg
      logic [7:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                          q <= reg_reset_val(g);
         else if (wr_en && wr_addr == 8'(g))  q <= wr_data;
      end
      assign cfg_flat[g*8 +: 8] = q;
   end

   logic por_q, por_pend;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         por_q        <= 1'b1;
         por_pend     <= 1'b0;
         search_start <= 1'b0;
      end else begin
         search_start <= wr_en && (wr_addr == 8'(STRB_ADDR));
         if (bus_stop) begin
            if (por_pend) por_q <= 1'b0;
            por_pend <= 1'b0;
         end else if (rd_take && rd_addr == 8'(STAT0)) begin
            por_pend <= 1'b1;
         end
      end
   end

   assign por_flag = por_q;

   always_comb begin
      rd_data = 8'h00;
      for (int k = 0; k < NUM_WREG; k++) begin
         if (rd_addr == 8'(k)) rd_data = cfg_flat[k*8 +: 8];
      end
      if (rd_addr == 8'(STAT0)) rd_data = {por_q, st_flags, 4'b0000};
      if (rd_addr == 8'(STAT1)) rd_data = {st_band, st_adc};
   end

   // R7: the search pulse never lasts two cycles
   assert_strobe_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      search_start |=> !search_start);

   // R6: the power-up flag only drops after a stop condition
   assert_por_needs_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(por_q) |-> $past(bus_stop));

   // R9: a write aimed outside the writable space leaves all registers alone
   assert_ro_discard_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr >= 8'(NUM_WREG)) |=> $stable(cfg_flat));

endmodule

// File: rtl/cfgbus_slave.sv
module cfgbus_slave
   import cfgbus_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR    = 7'b1100000,
   parameter int         NUM_WREG    = 12,
   parameter int         SYNC_STAGES = 2,
   parameter int         STRB_ADDR   = 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  scl_i,
   input  logic                  sda_i,
   output logic                  sda_oe,
   input  logic                  addr_sel,
   input  logic [2:0]            st_flags,
   input  logic [4:0]            st_band,
   input  logic [2:0]            st_adc,
   output logic [NUM_WREG*8-1:0] cfg_flat,
   output logic [14:0]           n_word,
   output logic [4:0]            r_div,
   output logic [7:0]            lpf_code,
   output logic [4:0]            vco_start,
   output logic                  auto_en,
   output logic                  div8_sel,
   output logic                  search_start
);

   initial begin
      assert (NUM_WREG >= 9) else $error("cfgbus_slave: decoded fields need at least 9 registers");
   end

   logic       scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
   logic       wr_en, rd_take, por_flag;
   logic [7:0] wr_addr, wr_data, rd_addr, rd_data;

   cfgbus_pinsync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_i    (scl_i),
      .sda_i    (sda_i),
      .scl_s    (scl_s),
      .sda_s    (sda_s),
      .scl_rise (scl_rise),
      .scl_fall (scl_fall),
      .start_det(start_det),
      .stop_det (stop_det)
   );

   cfgbus_proto #(.DEV_ADDR(DEV_ADDR)) u_proto (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_s    (scl_s),
      .sda_s    (sda_s),
      .scl_rise (scl_rise),
      .scl_fall (scl_fall),
      .start_det(start_det),
      .stop_det (stop_det),
      .addr_sel (addr_sel),
      .rd_data  (rd_data),
      .sda_oe   (sda_oe),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .rd_addr  (rd_addr),
      .rd_take  (rd_take)
   );

   cfgbus_regfile #(.NUM_WREG(NUM_WREG), .STRB_ADDR(STRB_ADDR)) u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (wr_en),
      .wr_addr     (wr_addr),
      .wr_data     (wr_data),
      .rd_addr     (rd_addr),
      .rd_take     (rd_take),
      .bus_stop    (stop_det),
      .st_flags    (st_flags),
      .st_band     (st_band),
      .st_adc      (st_adc),
      .rd_data     (rd_data),
      .cfg_flat    (cfg_flat),
      .search_start(search_start),
      .por_flag    (por_flag)
   );

   assign n_word    = {cfg_flat[6:0], cfg_flat[15:8]};
   assign r_div     = cfg_flat[5*8 +: 5];
   assign div8_sel  = cfg_flat[6*8 + 7];
   assign vco_start = cfg_flat[7*8 + 3 +: 5];
   assign auto_en   = cfg_flat[7*8 + 2];
   assign lpf_code  = cfg_flat[8*8 +: 8];

   // R6: the power-up flag cannot return once cleared
   assert_por_no_reset_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !por_flag |=> !por_flag);

endmodule

// File: tb/sim_cfgbus_slave.sv
module sim_cfgbus_slave;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        scl_m = 1'b1, sda_m = 1'b1;
   logic        addr_sel = 1'b0;
   logic [2:0]  st_flags = 3'b000;
   logic [4:0]  st_band = 5'h00;
   logic [2:0]  st_adc = 3'b000;
   logic        sda_oe, auto_en, div8_sel, search_start;
   logic [95:0] cfg_flat;
   logic [14:0] n_word;
   logic [4:0]  r_div, vco_start;
   logic [7:0]  lpf_code;
   wire         sda_line = sda_m & ~sda_oe;

   always #4 clk = ~clk;

   cfgbus_slave u0 (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
      .addr_sel(addr_sel), .st_flags(st_flags), .st_band(st_band), .st_adc(st_adc),
      .cfg_flat(cfg_flat), .n_word(n_word), .r_div(r_div), .lpf_code(lpf_code),
      .vco_start(vco_start), .auto_en(auto_en), .div8_sel(div8_sel),
      .search_start(search_start)
   );

   int          n_chk = 0, n_fail = 0;
   int          strobe_cnt = 0, exp_strb = 0, mism = 0;
   logic [7:0]  exp_reg [12];
   logic        exp_por = 1'b1;
   logic        cmp_en = 1'b0;
   logic [7:0]  wbuf [8];

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [95:0] model_flat();
      logic [95:0] v;
      for (int k = 0; k < 12; k++) v[k*8 +: 8] = exp_reg[k];
      return v;
   endfunction

   function automatic logic [7:0] exp_read(input int a);
      if (a < 12)  return exp_reg[a];
      if (a == 12) return {exp_por, st_flags, 4'b0000};
      if (a == 13) return {st_band, st_adc};
      return 8'h00;
   endfunction

   always @(posedge clk) if (rst_n && search_start) strobe_cnt++;

   // reference register image compared on every clock outside write windows
   always @(negedge clk) if (rst_n && cmp_en && cfg_flat !== model_flat()) mism++;

   task automatic wq();
      repeat (20) @(posedge clk);
      #1;
   endtask

   task automatic b_start();
      sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
   endtask

   task automatic b_stop();
      sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
   endtask

   task automatic tx_byte(input logic [7:0] b, output bit ack);
      for (int i = 7; i >= 0; i--) begin
         sda_m = b[i]; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
      end
      sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); ack = ~sda_line; wq(); scl_m = 1'b0; wq();
   endtask

   task automatic rx_byte(input bit mack, output logic [7:0] b);
      sda_m = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         wq(); scl_m = 1'b1; wq(); b[i] = sda_line; wq(); scl_m = 1'b0;
      end
      sda_m = ~mack; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq(); sda_m = 1'b1;
   endtask

   task automatic wr_tx(input logic [7:0] dev, input logic [7:0] ra, input int nb,
                        output bit all_ack);
      bit a, dev_ok;
      cmp_en = 1'b0;
      b_start();
      tx_byte(dev, a); dev_ok = a; all_ack = a;
      tx_byte(ra, a); all_ack &= a;
      for (int k = 0; k < nb; k++) begin
         tx_byte(wbuf[k], a); all_ack &= a;
      end
      b_stop();
      repeat (5) @(posedge clk);
      if (dev_ok) begin
         for (int k = 0; k < nb; k++) begin
            if (int'(ra) + k < 12) exp_reg[int'(ra) + k] = wbuf[k];
            if (int'(ra) + k == 1) exp_strb++;
         end
      end
      #1 cmp_en = 1'b1;
   endtask

   task automatic rd_tx(input logic [7:0] dev, input logic [7:0] ra, input int nb,
                        input string tag);
      bit a, all_ack, saw;
      logic [7:0] b, e;
      saw = 1'b0;
      b_start();
      tx_byte(dev, a); all_ack = a;
      tx_byte(ra, a); all_ack &= a;
      b_start();
      tx_byte(dev | 8'h01, a); all_ack &= a;
      chk(all_ack, "R4 read setup acknowledged", int'(all_ack), 1);
      for (int k = 0; k < nb; k++) begin
         e = exp_read(int'(ra) + k);
         rx_byte(k != nb - 1, b);
         chk(b == e, tag, int'(b), int'(e));
         if (int'(ra) + k == 12) saw = 1'b1;
      end
      chk(sda_line == 1'b1, "R3 SDA released after NACK", int'(sda_line), 1);
      b_stop();
      repeat (5) @(posedge clk);
      if (saw) exp_por = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      bit ok;
      for (int k = 0; k < 12; k++) exp_reg[k] = 8'h00;
      exp_reg[0] = 8'h03; exp_reg[1] = 8'hB6; exp_reg[5] = 8'h04;
      exp_reg[6] = 8'hC0; exp_reg[7] = 8'hCC; exp_reg[8] = 8'h4B;
      repeat (10) @(posedge clk);
      #1 rst_n = 1'b1;
      repeat (5) @(posedge clk);
      #1 cmp_en = 1'b1;

      // reset state
      chk(n_word == 15'd950, "R5 reset divide word", int'(n_word), 950);
      chk(r_div == 5'd4, "R8 reset r_div", int'(r_div), 4);
      chk(lpf_code == 8'h4B, "R8 reset lpf_code", int'(lpf_code), 'h4B);
      chk(vco_start == 5'b11001, "R8 reset vco_start", int'(vco_start), 'h19);
      chk(auto_en && div8_sel, "R8 reset auto_en/div8_sel", int'({auto_en, div8_sel}), 3);
      chk(cfg_flat == model_flat(), "R8 reset register image", int'(cfg_flat[31:0]), int'(model_flat() >> 0));
      chk(!sda_oe, "R4 bus released after reset", int'(sda_oe), 0);

      // R1: wrong address is ignored
      wbuf[0] = 8'h11;
      wr_tx(8'hC2, 8'h08, 1, ok);
      chk(!ok, "R1 foreign address not acknowledged", int'(ok), 0);
      chk(lpf_code == 8'h4B, "R1 foreign write no effect", int'(lpf_code), 'h4B);

      // R2: multi-byte write with pointer increment
      wbuf[0] = 8'h1F; wbuf[1] = 8'h80; wbuf[2] = 8'h98; wbuf[3] = 8'h40;
      wr_tx(8'hC0, 8'h05, 4, ok);
      chk(ok, "R4 all write bytes acknowledged", int'(ok), 1);
      chk(r_div == 5'h1F, "R2 reg 0x05", int'(r_div), 'h1F);
      chk(vco_start == 5'h13 && !auto_en, "R2 reg 0x07 fields", int'({vco_start, auto_en}), 'h26);
      chk(lpf_code == 8'h40, "R2 reg 0x08 via increment", int'(lpf_code), 'h40);
      chk(strobe_cnt == exp_strb, "R7 no search pulse on 0x05..0x08", strobe_cnt, exp_strb);

      // R7 / R5: strobe only for 0x01
      wbuf[0] = 8'h02;
      wr_tx(8'hC0, 8'h00, 1, ok);
      chk(strobe_cnt == exp_strb && exp_strb == 0, "R7 write 0x00 alone no pulse", strobe_cnt, 0);
      wbuf[0] = 8'h01; wbuf[1] = 8'h23;
      wr_tx(8'hC0, 8'h00, 2, ok);
      chk(n_word == 15'h0123, "R5 divide word split", int'(n_word), 'h123);
      chk(strobe_cnt == 1, "R7 pulse after 0x01 write", strobe_cnt, 1);
      wbuf[0] = 8'h55;
      wr_tx(8'hC0, 8'h01, 1, ok);
      chk(strobe_cnt == 2, "R7 direct 0x01 write pulse", strobe_cnt, 2);

      // R1: address pin high
      addr_sel = 1'b1;
      wbuf[0] = 8'h77;
      wr_tx(8'hC0, 8'h09, 1, ok);
      chk(!ok, "R1 C0 ignored with pin high", int'(ok), 0);
      wbuf[0] = 8'h8B;
      wr_tx(8'hC2, 8'h09, 1, ok);
      chk(ok && cfg_flat[79:72] == 8'h8B, "R1 C2 accepted with pin high", int'(cfg_flat[79:72]), 'h8B);

      // R3: multi-byte read
      rd_tx(8'hC2, 8'h05, 5, "R3 sequential read");

      // R6: status and power-up flag
      st_flags = 3'b101; st_band = 5'h0A; st_adc = 3'b010;
      wbuf[0] = 8'h00;
      wr_tx(8'hC2, 8'h0C, 1, ok);
      rd_tx(8'hC2, 8'h0D, 1, "R6 status byte 0x0D");
      rd_tx(8'hC2, 8'h0C, 2, "R6 flag still set before stop");
      rd_tx(8'hC2, 8'h0C, 1, "R6 flag cleared after stop");

      // R9: writes into status space discarded, out-of-range reads zero
      wbuf[0] = 8'hAA; wbuf[1] = 8'h77; wbuf[2] = 8'h66;
      wr_tx(8'hC2, 8'h0B, 3, ok);
      chk(ok, "R9 status writes acknowledged", int'(ok), 1);
      rd_tx(8'hC2, 8'h0B, 3, "R9 readback across status");
      rd_tx(8'hC2, 8'h10, 1, "R9 unmapped reads zero");
      rd_tx(8'hC2, 8'h00, 2, "R9 writable readback");

      chk(mism == 0, "R8 register image on every clock", mism, 0);
      chk(strobe_cnt == exp_strb, "R7 total pulses", strobe_cnt, exp_strb);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule